// File: doc/BRIEF.md
# Passive LCD Panel Timing Generator

This block produces the scan timing for a passive (STN) LCD panel. A pixel counter and a line counter step through a frame whose geometry comes from a set of configuration inputs. Decoded from the two counters are a per-line pulse, a per-frame pulse and a display-enable window. A MOD signal flips at a programmable rate so that the panel drive alternates. Each of the two pulses has its own polarity select.

The horizontal total and the horizontal active width are given in units of 8 pixels, stored as value+1. The active window starts 22 pixels after the programmed horizontal offset. The MOD rate field selects between one flip per frame pulse and one flip every n line pulses. All configuration inputs are captured into a shadow copy only at reset and at the end of a frame, so a frame never changes shape part way through. An error flag reports horizontal settings that a passive panel cannot use. Timing keeps running with those settings all the same.

Top module: `stn_timing_gen`

## Requirements
- R1: Each line lasts (htot_units+1)*8 pixel clocks; the pixel position runs 0 up to that total minus 1 and then returns to 0.
- R2: Each frame lasts (vtot_lines+1) lines; the line position advances only when a line ends, and it returns to 0 after the last line.
- R3: Configuration inputs are captured at reset and at the last pixel of the last line, and at no other time; a change made in the middle of a frame has no effect on any output until the next frame begins.
- R4: The line pulse is active at pixel positions from lp_pos+1 up to, but not including, lp_pos+1+lp_len+1, on every line; with lp_active_high=1 the output is high while active, with 0 it is low while active.
- R5: disp_en is high exactly when the pixel position lies in [hact_offset+22, hact_offset+22+(hact_units+1)*8) and the line position lies in [vact_first, vact_first+vact_lines+1).
- R6: The frame pulse is active for line positions from fp_line up to, but not including, fp_line+fp_len+1, for every pixel of those lines; fp_active_high selects the polarity as for the line pulse.
- R7: cfg_err is high exactly when the captured settings break a passive-panel rule: line pulse start (lp_pos+1) not greater than hact_offset+22+active width, line pulse end (start+lp_len+1) not less than the line total, active width below 32 pixels, or active width not a multiple of 16 pixels.
- R8: With mod_period=0, mod_out inverts one clock after the pixel at position 0 of line fp_line, once per frame.
- R9: With mod_period=n (n>0), mod_out inverts one clock after every n-th line pulse start (pixel lp_pos+1), counted continuously across lines and frames; a count already at n-1 or more inverts on the next start; the count is cleared while mod_period is 0.
- R10: While rst is high, the position is line 0, pixel 0 and mod_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| htot_units | input | 7 | Line length: (value+1)*8 pixels |
| hact_units | input | 7 | Active width: (value+1)*8 pixels |
| hact_offset | input | 10 | Active window start, added to the fixed 22-pixel offset |
| lp_pos | input | 10 | Line pulse start: value+1 pixels |
| lp_len | input | 7 | Line pulse width: value+1 pixels |
| lp_active_high | input | 1 | Line pulse polarity, 1 = active high |
| vtot_lines | input | 10 | Frame length: value+1 lines |
| vact_lines | input | 10 | Active height: value+1 lines |
| vact_first | input | 10 | First active line |
| fp_line | input | 10 | First line of the frame pulse |
| fp_len | input | 3 | Frame pulse width: value+1 lines |
| fp_active_high | input | 1 | Frame pulse polarity, 1 = active high |
| mod_period | input | 6 | 0 = MOD flips per frame pulse, n = every n line pulses |
| line_pulse | output | 1 | Line pulse |
| frame_pulse | output | 1 | Frame pulse |
| disp_en | output | 1 | Display-enable window |
| mod_out | output | 1 | Alternating MOD signal |
| cfg_err | output | 1 | Captured horizontal settings are illegal |

## Verification
The bench flips the line pulse polarity and moves the line pulse into the active area in the middle of a frame. A design that captured settings early would change the pulse level or raise cfg_err one frame too soon. It measures line and frame periods between pulse edges, which catches an off-by-one in the value+1 or times-8 scaling. It also counts MOD flips over a frame for rates 2 and 3, where a counter that restarts on each line or frame would flip the wrong number of times. Error cases hit each of the four rules one at a time, including a width that is 32 or more but not a multiple of 16.

// File: rtl/stn_pkg.sv
package stn_pkg;

    localparam int HREG_W        = 7;
    localparam int POS_W         = 10;
    localparam int FPW_W         = 3;
    localparam int MODR_W        = 6;
    localparam int HCNT_W        = 10;
    localparam int VCNT_W        = 10;
    localparam int GEO_W         = 12;
    localparam int HDS_OFFSET    = 22;
    localparam int HUNIT_SHIFT   = 3;
    localparam int HDP_MIN_UNITS = 4;

    typedef logic [GEO_W-1:0] geo_t;

    typedef struct packed {
        logic [HREG_W-1:0] ht;
        logic [HREG_W-1:0] hdp;
        logic [POS_W-1:0]  hds;
        logic [POS_W-1:0]  lps;
        logic [HREG_W-1:0] lpw;
        logic [POS_W-1:0]  vt;
        logic [POS_W-1:0]  vdp;
        logic [POS_W-1:0]  vds;
        logic [POS_W-1:0]  fps;
        logic [FPW_W-1:0]  fpw;
        logic [MODR_W-1:0] mod_rate;
        logic              line_pol;
        logic              frame_pol;
    } stn_cfg_t;

    typedef struct packed {
        geo_t h_total;
        geo_t de_h_start;
        geo_t de_h_end;
        geo_t lp_start;
        geo_t lp_end;
        geo_t v_total;
        geo_t de_v_start;
        geo_t de_v_end;
        geo_t fp_start;
        geo_t fp_end;
    } stn_geom_t;

    typedef struct packed {
        logic [HCNT_W-1:0] h;
        logic [VCNT_W-1:0] v;
    } stn_pos_t;

    function automatic geo_t units_to_px(input logic [HREG_W-1:0] u);
        geo_t t;
        t = geo_t'(u) + geo_t'(1);
        return t << HUNIT_SHIFT;
    endfunction

    function automatic geo_t plus_one(input logic [POS_W-1:0] x);
        return geo_t'(x) + geo_t'(1);
    endfunction

    function automatic logic in_win(input geo_t x, input geo_t lo, input geo_t hi);
        return (x >= lo) && (x < hi);
    endfunction

    function automatic stn_geom_t derive_geom(input stn_cfg_t c);
        stn_geom_t g;
        g.h_total    = units_to_px(c.ht);
        g.de_h_start = geo_t'(c.hds) + geo_t'(HDS_OFFSET);
        g.de_h_end   = g.de_h_start + units_to_px(c.hdp);
        g.lp_start   = plus_one(c.lps);
        g.lp_end     = g.lp_start + geo_t'(c.lpw) + geo_t'(1);
        g.v_total    = plus_one(c.vt);
        g.de_v_start = geo_t'(c.vds);
        g.de_v_end   = g.de_v_start + plus_one(c.vdp);
        g.fp_start   = geo_t'(c.fps);
        g.fp_end     = g.fp_start + geo_t'(c.fpw) + geo_t'(1);
        return g;
    endfunction

    function automatic logic geom_illegal(input stn_cfg_t c, input stn_geom_t g);
        logic gap_bad;
        logic tail_bad;
        logic width_bad;
        gap_bad   = !(g.lp_start > g.de_h_end);
        tail_bad  = !(g.lp_end < g.h_total);
        width_bad = (c.hdp < HREG_W'(HDP_MIN_UNITS - 1)) || !c.hdp[0];
        return gap_bad || tail_bad || width_bad;
    endfunction

endpackage

// File: rtl/stn_cfg_shadow.sv
module stn_cfg_shadow
    import stn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  stn_cfg_t          cfg_in,
    output stn_geom_t         geom,
    output logic              line_pol,
    output logic              frame_pol,
    output logic [MODR_W-1:0] mod_rate,
    output logic              cfg_err
);

    stn_geom_t geom_next;
    logic      err_next;

    always_comb begin
        geom_next = derive_geom(cfg_in);
        err_next  = geom_illegal(cfg_in, geom_next);
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            geom      <= geom_next;
            line_pol  <= cfg_in.line_pol;
            frame_pol <= cfg_in.frame_pol;
            mod_rate  <= cfg_in.mod_rate;
            cfg_err   <= err_next;
        end
    end

    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(geom) && $stable(cfg_err) && $stable(line_pol)
                   && $stable(frame_pol) && $stable(mod_rate)));

endmodule

// File: rtl/stn_scan_counter.sv
module stn_scan_counter
    import stn_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  geo_t     h_total,
    input  geo_t     v_total,
    output stn_pos_t pos,
    output logic     line_end,
    output logic     frame_end
);

    always_comb begin
        line_end  = (geo_t'(pos.h) == h_total - geo_t'(1));
        frame_end = line_end && (geo_t'(pos.v) == v_total - geo_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (line_end) begin
            pos.h <= '0;
            if (frame_end) pos.v <= '0;
            else           pos.v <= pos.v + VCNT_W'(1);
        end else begin
            pos.h <= pos.h + HCNT_W'(1);
        end
    end

    assert_h_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        geo_t'(pos.h) < h_total);

    assert_h_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (pos.h == '0));

    assert_v_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(pos.v));

    assert_v_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        geo_t'(pos.v) < v_total);

    assert_reset_pos_R10: assert property (@(posedge clk)
        rst |=> (pos.h == '0 && pos.v == '0));

endmodule

// File: rtl/stn_pulse_decode.sv
module stn_pulse_decode
    import stn_pkg::*;
(
    input  stn_pos_t  pos,
    input  stn_geom_t geom,
    input  logic      line_pol,
    input  logic      frame_pol,
    output logic      line_pulse,
    output logic      frame_pulse,
    output logic      disp_en,
    output logic      lp_evt,
    output logic      fp_evt
);

    geo_t hx;
    geo_t vx;
    logic lp_act;
    logic fp_act;

    always_comb begin
        hx     = geo_t'(pos.h);
        vx     = geo_t'(pos.v);
        lp_act = in_win(hx, geom.lp_start, geom.lp_end);
        fp_act = in_win(vx, geom.fp_start, geom.fp_end);
        // Output level: active state when polarity is 1, inverted otherwise.
        line_pulse  = ~(lp_act ^ line_pol);
        frame_pulse = ~(fp_act ^ frame_pol);
        disp_en     = in_win(hx, geom.de_h_start, geom.de_h_end)
                   && in_win(vx, geom.de_v_start, geom.de_v_end);
        lp_evt = (hx == geom.lp_start) && (geom.lp_start < geom.h_total);
        fp_evt = (hx == '0) && (vx == geom.fp_start) && (geom.fp_start < geom.v_total);
    end

endmodule

// File: rtl/stn_mod_gen.sv
module stn_mod_gen
    import stn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODR_W-1:0] rate,
    input  logic              lp_evt,
    input  logic              fp_evt,
    output logic              mod_out
);

    logic [MODR_W-1:0] lcnt;
    logic              per_line;
    logic              count_done;
    logic              toggle;

    always_comb begin
        per_line   = (rate != '0);
        count_done = per_line && (lcnt >= rate - MODR_W'(1));
        toggle     = per_line ? (lp_evt && count_done) : fp_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_out <= 1'b0;
            lcnt    <= '0;
        end else begin
            if (toggle) mod_out <= ~mod_out;
            if (!per_line)       lcnt <= '0;
            else if (lp_evt)     lcnt <= count_done ? '0 : lcnt + MODR_W'(1);
        end
    end

    assert_mod_frame_only_R8: assert property (@(posedge clk) disable iff (rst)
        (rate == '0 && !fp_evt) |=> $stable(mod_out));

    assert_mod_line_only_R9: assert property (@(posedge clk) disable iff (rst)
        (rate != '0 && !lp_evt) |=> $stable(mod_out));

    assert_mod_reset_R10: assert property (@(posedge clk)
        rst |=> !mod_out);

endmodule

// File: rtl/stn_timing_gen.sv
module stn_timing_gen
    import stn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HREG_W-1:0] htot_units,
    input  logic [HREG_W-1:0] hact_units,
    input  logic [POS_W-1:0]  hact_offset,
    input  logic [POS_W-1:0]  lp_pos,
    input  logic [HREG_W-1:0] lp_len,
    input  logic              lp_active_high,
    input  logic [POS_W-1:0]  vtot_lines,
    input  logic [POS_W-1:0]  vact_lines,
    input  logic [POS_W-1:0]  vact_first,
    input  logic [POS_W-1:0]  fp_line,
    input  logic [FPW_W-1:0]  fp_len,
    input  logic              fp_active_high,
    input  logic [MODR_W-1:0] mod_period,
    output logic              line_pulse,
    output logic              frame_pulse,
    output logic              disp_en,
    output logic              mod_out,
    output logic              cfg_err
);

    stn_cfg_t          cfg_live;
    stn_geom_t         geom;
    stn_pos_t          pos;
    logic              line_pol;
    logic              frame_pol;
    logic [MODR_W-1:0] mod_rate;
    logic              line_end;
    logic              frame_end;
    logic              lp_evt;
    logic              fp_evt;

    always_comb begin
        cfg_live.ht        = htot_units;
        cfg_live.hdp       = hact_units;
        cfg_live.hds       = hact_offset;
        cfg_live.lps       = lp_pos;
        cfg_live.lpw       = lp_len;
        cfg_live.vt        = vtot_lines;
        cfg_live.vdp       = vact_lines;
        cfg_live.vds       = vact_first;
        cfg_live.fps       = fp_line;
        cfg_live.fpw       = fp_len;
        cfg_live.mod_rate  = mod_period;
        cfg_live.line_pol  = lp_active_high;
        cfg_live.frame_pol = fp_active_high;
    end

    stn_cfg_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .load      (frame_end),
        .cfg_in    (cfg_live),
        .geom      (geom),
        .line_pol  (line_pol),
        .frame_pol (frame_pol),
        .mod_rate  (mod_rate),
        .cfg_err   (cfg_err)
    );

    stn_scan_counter u_scan (
        .clk       (clk),
        .rst       (rst),
        .h_total   (geom.h_total),
        .v_total   (geom.v_total),
        .pos       (pos),
        .line_end  (line_end),
        .frame_end (frame_end)
    );

    stn_pulse_decode u_decode (
        .pos         (pos),
        .geom        (geom),
        .line_pol    (line_pol),
        .frame_pol   (frame_pol),
        .line_pulse  (line_pulse),
        .frame_pulse (frame_pulse),
        .disp_en     (disp_en),
        .lp_evt      (lp_evt),
        .fp_evt      (fp_evt)
    );

    stn_mod_gen u_mod (
        .clk     (clk),
        .rst     (rst),
        .rate    (mod_rate),
        .lp_evt  (lp_evt),
        .fp_evt  (fp_evt),
        .mod_out (mod_out)
    );

    assert_frame_end_R3: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (pos.h == '0 && pos.v == '0));

endmodule

// File: tb/sim_stn_timing_gen.sv
module sim_stn_timing_gen;
    import stn_pkg::*;

    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    stn_cfg_t cfg;
    logic line_pulse, frame_pulse, disp_en, mod_out, cfg_err;

    stn_timing_gen u0 (
        .clk(clk), .rst(rst),
        .htot_units(cfg.ht), .hact_units(cfg.hdp), .hact_offset(cfg.hds),
        .lp_pos(cfg.lps), .lp_len(cfg.lpw), .lp_active_high(cfg.line_pol),
        .vtot_lines(cfg.vt), .vact_lines(cfg.vdp), .vact_first(cfg.vds),
        .fp_line(cfg.fps), .fp_len(cfg.fpw), .fp_active_high(cfg.frame_pol),
        .mod_period(cfg.mod_rate),
        .line_pulse(line_pulse), .frame_pulse(frame_pulse), .disp_en(disp_en),
        .mod_out(mod_out), .cfg_err(cfg_err)
    );

    int checks = 0;
    int failures = 0;
    bit chk_en = 0;
    bit done = 0;
    int cyc = 0;

    // Reference model state, built from the requirements.
    stn_cfg_t m_cfg;
    int mh = 0, mv = 0, m_lc = 0, m_frames = 0;
    bit m_mod = 0;
    bit m_lpe, m_fpe;

    function automatic int f_ht(stn_cfg_t c); return (int'(c.ht) + 1) * 8; endfunction
    function automatic int f_vt(stn_cfg_t c); return int'(c.vt) + 1; endfunction

    function automatic bit exp_line(stn_cfg_t c, int h);
        int s = int'(c.lps) + 1;
        int e = s + int'(c.lpw) + 1;
        bit a = (h >= s) && (h < e);
        return c.line_pol ? a : !a;
    endfunction

    function automatic bit exp_frame(stn_cfg_t c, int v);
        int s = int'(c.fps);
        int e = s + int'(c.fpw) + 1;
        bit a = (v >= s) && (v < e);
        return c.frame_pol ? a : !a;
    endfunction

    function automatic bit exp_de(stn_cfg_t c, int h, int v);
        int hs = int'(c.hds) + 22;
        int he = hs + (int'(c.hdp) + 1) * 8;
        int vs = int'(c.vds);
        int ve = vs + int'(c.vdp) + 1;
        return (h >= hs) && (h < he) && (v >= vs) && (v < ve);
    endfunction

    function automatic bit exp_err(stn_cfg_t c);
        int wpx = (int'(c.hdp) + 1) * 8;
        int s = int'(c.lps) + 1;
        int e = s + int'(c.lpw) + 1;
        return !(s > int'(c.hds) + 22 + wpx) || !(e < f_ht(c)) || (wpx < 32) || (wpx % 16 != 0);
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b (h=%0d v=%0d)", tag, act, exp, mh, mv);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            mh = 0; mv = 0; m_cfg = cfg; m_mod = 0; m_lc = 0;
        end else begin
            m_lpe = (mh == int'(m_cfg.lps) + 1);
            m_fpe = (mh == 0) && (mv == int'(m_cfg.fps));
            if (m_cfg.mod_rate == 0) begin
                m_lc = 0;
                if (m_fpe) m_mod = !m_mod;
            end else if (m_lpe) begin
                if (m_lc >= int'(m_cfg.mod_rate) - 1) begin
                    m_lc = 0;
                    m_mod = !m_mod;
                end else m_lc++;
            end
            if (mh == f_ht(m_cfg) - 1) begin
                mh = 0;
                if (mv == f_vt(m_cfg) - 1) begin
                    mv = 0;
                    m_cfg = cfg;
                    m_frames++;
                end else mv++;
            end else mh++;
        end
        if (cyc == WATCHDOG && !done) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (chk_en && !rst) begin
            check(line_pulse,  exp_line(m_cfg, mh), "R4");
            check(frame_pulse, exp_frame(m_cfg, mv), "R6");
            check(disp_en,     exp_de(m_cfg, mh, mv), "R5");
            check(mod_out,     m_mod, (m_cfg.mod_rate == 0) ? "R8" : "R9");
            check(cfg_err,     exp_err(m_cfg), "R7");
        end
    end

    task automatic wait_frames(input int n);
        int f0 = m_frames;
        while (m_frames < f0 + n) @(negedge clk);
    endtask

    task automatic wait_line_start();
        do @(negedge clk); while (mh != 0);
    endtask

    function automatic logic pick(input bit frm);
        return frm ? frame_pulse : line_pulse;
    endfunction

    task automatic measure_period(input bit frm, output int n);
        logic prev, cur;
        cur = pick(frm);
        do begin prev = cur; @(negedge clk); cur = pick(frm); end while (!(!prev && cur));
        n = 0;
        do begin prev = cur; @(negedge clk); n++; cur = pick(frm); end while (!(!prev && cur));
    endtask

    task automatic count_mod_flips(input int len, output int n);
        logic prev;
        n = 0;
        prev = mod_out;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (mod_out !== prev) n++;
            prev = mod_out;
        end
    endtask

    task automatic set_base();
        cfg.ht = 7'd9;   cfg.hdp = 7'd3;  cfg.hds = 10'd0;
        cfg.lps = 10'd56; cfg.lpw = 7'd3; cfg.line_pol = 1'b1;
        cfg.vt = 10'd5;  cfg.vdp = 10'd3; cfg.vds = 10'd1;
        cfg.fps = 10'd1; cfg.fpw = 3'd1;  cfg.frame_pol = 1'b1;
        cfg.mod_rate = 6'd0;
    endtask

    initial begin
        int n;
        bit a;
        void'($urandom(32'd20240611));
        set_base();
        repeat (3) @(negedge clk);
        // R10: reset state
        check(mod_out, 1'b0, "R10");
        check(disp_en, 1'b0, "R10");
        check(line_pulse, 1'b0, "R10");
        rst = 1'b0;
        chk_en = 1'b1;

        // R1 / R2: periods of base geometry (80 px, 6 lines)
        measure_period(1'b0, n);
        check_int(n, 80, "R1");
        measure_period(1'b1, n);
        check_int(n, 480, "R2");
        check(cfg_err, 1'b0, "R7");

        // R8: one flip per frame with rate 0
        wait_frames(1);
        a = mod_out;
        wait_frames(1);
        check(mod_out, !a, "R8");

        // R3: polarity change mid-frame held off until frame boundary
        repeat (10) @(negedge clk);
        cfg.line_pol = 1'b0;
        wait_line_start();
        check(line_pulse, 1'b0, "R3");
        wait_frames(1);
        wait_line_start();
        check(line_pulse, 1'b1, "R3");
        cfg.line_pol = 1'b1;
        wait_frames(1);

        // R7: each rule, error only after capture (R3)
        cfg.lps = 10'd40;
        @(negedge clk);
        check(cfg_err, 1'b0, "R3");
        wait_frames(1);
        check(cfg_err, 1'b1, "R7");
        cfg.lps = 10'd70; cfg.hdp = 7'd4;
        wait_frames(1);
        check(cfg_err, 1'b1, "R7");
        cfg.hdp = 7'd2; cfg.lps = 10'd56;
        wait_frames(1);
        check(cfg_err, 1'b1, "R7");
        cfg.hdp = 7'd3; cfg.lpw = 7'd30;
        wait_frames(1);
        check(cfg_err, 1'b1, "R7");
        set_base();
        wait_frames(1);
        check(cfg_err, 1'b0, "R7");

        // R9: flips per frame of 6 line pulses
        cfg.mod_rate = 6'd2;
        wait_frames(1);
        count_mod_flips(480, n);
        check_int(n, 3, "R9");
        cfg.mod_rate = 6'd3;
        wait_frames(1);
        count_mod_flips(480, n);
        check_int(n, 2, "R9");

        // Random configurations checked every cycle against the model.
        for (int i = 0; i < 20; i++) begin
            cfg.ht = 7'(3 + $urandom % 8);
            cfg.hdp = 7'($urandom % 8);
            cfg.hds = 10'($urandom % 8);
            cfg.lps = 10'($urandom % f_ht(cfg));
            cfg.lpw = 7'($urandom % 8);
            cfg.vt = 10'(2 + $urandom % 12);
            cfg.vdp = 10'($urandom % 16);
            cfg.vds = 10'($urandom % 4);
            cfg.fps = 10'($urandom % (int'(cfg.vt) + 2));
            cfg.fpw = 3'($urandom % 8);
            cfg.mod_rate = 6'($urandom % 5);
            cfg.line_pol = 1'($urandom % 2);
            cfg.frame_pol = 1'($urandom % 2);
            wait_frames(1);
            check(cfg_err, exp_err(cfg), "R7");
            wait_frames(1);
        end

        chk_en = 1'b0;
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule